// File: doc/BRIEF.md
# Packed Double-to-Int32 Truncating Converter

This block takes a 128-bit operand made of two IEEE 754 double-precision numbers. It turns each one into a signed 32-bit integer by rounding toward zero. Both integers land in the low 64 bits of a 128-bit result, and the upper 64 bits are always zero. Each lane reports two flags of its own. The invalid flag marks a value that cannot be represented. The precision flag marks a conversion that dropped a nonzero fraction.

Special values, out-of-range magnitudes and the exact lower edge of the int32 range are all resolved inside the block. Every unrepresentable input yields the single indefinite pattern 0x80000000. The block is a fixed-latency pipeline with a one-bit valid qualifier and accepts a new operand on any cycle.

Top module: `dtoi_packed_trunc`

## Requirements
- R1: Operand bits [63:0] produce result bits [31:0] and flag bit 0. Operand bits [127:64] produce result bits [63:32] and flag bit 1.
- R2: Result bits [127:64] read as zero in every cycle.
- R3: A non-integral in-range input yields its integer part with the fraction discarded toward zero for either sign (3.75 gives 3, -3.75 gives -3).
- R4: A finite input whose truncated value lies outside [-2^31, 2^31-1] sets that lane's invalid flag and yields 0x80000000.
- R5: The precision flag is set exactly when a finite, representable input had nonzero fraction bits discarded. An exactly integral input leaves it clear.
- R6: An input whose 11-bit exponent field (bits [62:52] of a lane) is all ones (either NaN or either infinity) sets invalid, yields 0x80000000, and leaves precision clear.
- R7: An input that truncates to exactly -2^31 (e.g. -2147483648.5) is in range: it yields 0x80000000 with invalid clear and precision set if a fraction was dropped. 2147483647.75 yields 0x7FFFFFFF, and +2^31 and -2^31-1 are invalid.
- R8: Positive and negative zero yield 0 with both flags clear. A nonzero subnormal of either sign (exponent field zero) yields 0 with precision set.
- R9: `out_vld` rises exactly LATENCY cycles (default 10) after the clock edge that samples `in_vld`. Back-to-back inputs on consecutive cycles come out on consecutive cycles in order.
- R10: While `out_vld` is low, `out_res`, `out_inv` and `out_inx` keep the values of the last delivered result.
- R11: Reset clears all pipeline valid bits. `out_vld` stays low from reset until the first accepted operand has crossed the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the valid bits |
| in_vld | input | 1 | Operand valid |
| in_op | input | 128 | Two packed doubles, lane 0 in [63:0] |
| out_vld | output | 1 | Result valid |
| out_res | output | 128 | Two int32 results in [63:0], upper half zero |
| out_inv | output | 2 | Per-lane invalid flag |
| out_inx | output | 2 | Per-lane precision (inexact) flag |

## Verification
Lane pairs with different values in each half separate lane-0 from lane-1 routing. Positive and negative fractional values separate truncation from floor or nearest rounding. Values just inside and just outside both int32 edges, including -2147483648.5, -2147483649.0 and 2^31, pin down the range comparison and the sign handling at -2^31. NaNs, infinities, signed zeros and subnormals exercise the exponent-field corner cases. A generated sweep of magnitudes from 2^-3 to 2^33 covers every shift amount. Back-to-back bursts and gapped streams show that latency is exact and that outputs hold between results.

// File: rtl/dtoi_pkg.sv
package dtoi_pkg;

  localparam int F64_EXP_W = 11;
  localparam int F64_MAN_W = 52;
  localparam int F64_BIAS  = 1023;
  localparam int I32_W     = 32;
  localparam logic [I32_W-1:0] I32_INDEF = 32'h8000_0000;

  typedef struct packed {
    logic [I32_W-1:0] val;
    logic             inv;
    logic             inx;
  } lane_res_t;

  localparam int LANE_RES_W = $bits(lane_res_t);

  // Truncating conversion of one double to a signed 32-bit integer.
  function automatic lane_res_t f64_trunc_i32(input logic [63:0] x);
    lane_res_t r;
    logic                 s;
    logic [F64_EXP_W-1:0] e;
    logic [F64_MAN_W-1:0] m;
    logic [F64_MAN_W:0]   sig;
    logic [F64_MAN_W:0]   fmask;
    logic [F64_MAN_W:0]   ipart;
    logic [I32_W-1:0]     mag;
    int                   ue;
    int                   sh;
    s     = x[63];
    e     = x[62:52];
    m     = x[51:0];
    sig   = {1'b1, m};
    ue    = int'(e) - F64_BIAS;
    sh    = 0;
    fmask = '0;
    ipart = '0;
    mag   = '0;
    r     = '{val: '0, inv: 1'b0, inx: 1'b0};
    if (&e) begin
      r.val = I32_INDEF;
      r.inv = 1'b1;
    end else if (ue < 0) begin
      r.inx = (e != '0) || (m != '0);
    end else if (ue >= I32_W - 1) begin
      if (s && (ue == I32_W - 1) && (m[51:21] == '0)) begin
        r.val = I32_INDEF;
        r.inx = |m[20:0];
      end else begin
        r.val = I32_INDEF;
        r.inv = 1'b1;
      end
    end else begin
      sh    = F64_MAN_W - ue;
      ipart = sig >> sh;
      mag   = ipart[I32_W-1:0];
      fmask = (53'd1 << sh) - 53'd1;
      r.inx = |(sig & fmask);
      r.val = s ? (32'd0 - mag) : mag;
    end
    return r;
  endfunction

endpackage

// File: rtl/dtoi_lane.sv
module dtoi_lane
  import dtoi_pkg::*;
(
  input  logic [63:0] op,
  output lane_res_t   res
);

  logic exp_all_ones;
  logic is_zero;

  assign exp_all_ones = &op[62:52];
  assign is_zero      = (op[62:0] == '0);
  assign res          = f64_trunc_i32(op);

  always_comb begin
    if (exp_all_ones) begin
      assert_special_indef_R6: assert (res.inv && !res.inx && res.val == I32_INDEF)
        else $error("special input not mapped to indefinite");
    end
    if (is_zero) begin
      assert_zero_clean_R8: assert (!res.inv && !res.inx && res.val == '0)
        else $error("signed zero gave nonzero result or flag");
    end
    if (res.inv) begin
      assert_inv_pattern_R4: assert (res.val == I32_INDEF && !res.inx)
        else $error("invalid lane without indefinite pattern");
    end
  end

endmodule

// File: rtl/dtoi_pipe.sv
module dtoi_pipe #(
  parameter int DEPTH = 10,
  parameter int W     = 68
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);

  logic [DEPTH-1:0] v;
  logic [W-1:0]     d [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) v[0] <= 1'b0;
    else        v[0] <= in_v;
  end

  always_ff @(posedge clk) begin
    if (in_v) d[0] <= in_d;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) v[g] <= 1'b0;
      else        v[g] <= v[g-1];
    end
    always_ff @(posedge clk) begin
      if (v[g-1]) d[g] <= d[g-1];
    end
  end

  assign out_v = v[DEPTH-1];
  assign out_d = d[DEPTH-1];

endmodule

// File: rtl/dtoi_packed_trunc.sv
module dtoi_packed_trunc
  import dtoi_pkg::*;
#(
  parameter int LATENCY = 10,
  parameter int LANES   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [64*LANES-1:0]  in_op,
  output logic                 out_vld,
  output logic [64*LANES-1:0]  out_res,
  output logic [LANES-1:0]     out_inv,
  output logic [LANES-1:0]     out_inx
);

  localparam int PW = LANES * LANE_RES_W;
  localparam int CW = $clog2(LATENCY + 2);

  logic [PW-1:0] lane_flat;
  logic [PW-1:0] pipe_flat;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_res_t lr;
    lane_res_t pr;
    dtoi_lane u_lane (
      .op  (in_op[64*l +: 64]),
      .res (lr)
    );
    assign lane_flat[LANE_RES_W*l +: LANE_RES_W] = lr;
    assign pr = pipe_flat[LANE_RES_W*l +: LANE_RES_W];
    assign out_res[32*l +: 32] = pr.val;
    assign out_inv[l]          = pr.inv;
    assign out_inx[l]          = pr.inx;
  end

  assign out_res[64*LANES-1:32*LANES] = '0;

  dtoi_pipe #(.DEPTH(LATENCY), .W(PW)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (in_vld),
    .in_d  (lane_flat),
    .out_v (out_vld),
    .out_d (pipe_flat)
  );

  // Occupancy observer for the latency checks.
  logic [CW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + CW'(in_vld) - CW'(out_vld);
  end

  assert_inflight_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LATENCY))
    else $error("more operands in flight than pipeline stages");

  assert_no_orphan_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> inflight != '0)
    else $error("result without an accepted operand");

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |=> (out_vld || ($stable(out_res) && $stable(out_inv) && $stable(out_inx))))
    else $error("outputs moved without a new result");

  assert_reset_quiet_R11: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_vld)
    else $error("valid out asserted right after reset");

  assert_inv_excl_inx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ((out_inv & out_inx) == '0))
    else $error("invalid and precision both set in one lane");

endmodule

// File: tb/test_dtoi_packed_trunc.sv
module test_dtoi_packed_trunc;

  localparam int LAT = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [127:0] in_op = '0;
  logic         out_vld;
  logic [127:0] out_res;
  logic [1:0]   out_inv;
  logic [1:0]   out_inx;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dtoi_packed_trunc #(.LATENCY(LAT), .LANES(2)) i_dtoi_packed_trunc (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
    .out_vld(out_vld), .out_res(out_res), .out_inv(out_inv), .out_inx(out_inx)
  );

  typedef struct {
    logic         v;
    logic [127:0] op;
    string        tag;
  } stim_t;

  stim_t stim_q[$];

  logic         hv   [LAT];
  logic [63:0]  hres [LAT];
  logic [1:0]   hinv [LAT];
  logic [1:0]   hinx [LAT];
  string        htag [LAT];

  logic         have_last = 1'b0;
  logic [63:0]  last_res = '0;
  logic [1:0]   last_inv = '0;
  logic [1:0]   last_inx = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference built on real arithmetic.
  task automatic ref_lane(input logic [63:0] b, output logic [31:0] v,
                          output logic inv, output logic inx);
    real    r;
    integer t;
    v = 32'h8000_0000; inv = 1'b1; inx = 1'b0;
    if (b[62:52] != 11'h7FF) begin
      r = $bitstoreal(b);
      if (!(r >= 2147483648.0 || r <= -2147483649.0)) begin
        t   = $rtoi(r);
        v   = t;
        inv = 1'b0;
        inx = (r != $itor(t));
      end
    end
  endtask

  function automatic logic [127:0] pack2(input logic [63:0] lo, input logic [63:0] hi);
    return {hi, lo};
  endfunction

  task automatic push(input logic [63:0] lo, input logic [63:0] hi, input string tag);
    stim_t s;
    s.v = 1'b1; s.op = pack2(lo, hi); s.tag = tag;
    stim_q.push_back(s);
  endtask

  task automatic idle(input int n);
    stim_t s;
    s.v = 1'b0; s.op = '1; s.tag = "idle";
    for (int i = 0; i < n; i++) stim_q.push_back(s);
  endtask

  always @(negedge clk) begin
    stim_t s;
    logic [31:0] v0, v1;
    logic i0, i1, x0, x1;
    if (!rst_n) begin
      chk(out_vld == 1'b0, "R11", "valid during reset", {127'd0, out_vld}, 128'd0);
      for (int k = 0; k < LAT; k++) hv[k] = 1'b0;
      in_vld <= 1'b0;
    end else begin
      chk(out_res[127:64] == '0, "R2", "upper half", {64'd0, out_res[127:64]}, 128'd0);
      if (hv[LAT-1]) begin
        chk(out_vld == 1'b1, "R9", "valid at latency", {127'd0, out_vld}, 128'd1);
        chk(out_res[63:0] == hres[LAT-1], {"R1 ", htag[LAT-1]}, "result lanes",
            {64'd0, out_res[63:0]}, {64'd0, hres[LAT-1]});
        chk(out_inv == hinv[LAT-1], {"R4 ", htag[LAT-1]}, "invalid flags",
            {126'd0, out_inv}, {126'd0, hinv[LAT-1]});
        chk(out_inx == hinx[LAT-1], {"R5 ", htag[LAT-1]}, "precision flags",
            {126'd0, out_inx}, {126'd0, hinx[LAT-1]});
        have_last = 1'b1;
        last_res  = hres[LAT-1];
        last_inv  = hinv[LAT-1];
        last_inx  = hinx[LAT-1];
      end else begin
        chk(out_vld == 1'b0, have_last ? "R9" : "R11", "valid without operand",
            {127'd0, out_vld}, 128'd0);
        if (have_last) begin
          chk({out_res[63:0], out_inv, out_inx} == {last_res, last_inv, last_inx}, "R10",
              "hold between results", {60'd0, out_res[63:0], out_inv, out_inx},
              {60'd0, last_res, last_inv, last_inx});
        end
      end
      for (int k = LAT - 1; k > 0; k--) begin
        hv[k] = hv[k-1]; hres[k] = hres[k-1]; hinv[k] = hinv[k-1];
        hinx[k] = hinx[k-1]; htag[k] = htag[k-1];
      end
      if (stim_q.size() > 0) s = stim_q.pop_front();
      else begin s.v = 1'b0; s.op = '0; s.tag = "idle"; end
      ref_lane(s.op[63:0], v0, i0, x0);
      ref_lane(s.op[127:64], v1, i1, x1);
      hv[0] = s.v; hres[0] = {v1, v0}; hinv[0] = {i1, i0}; hinx[0] = {x1, x0};
      htag[0] = s.tag;
      in_vld <= s.v;
      in_op  <= s.op;
    end
  end

  initial begin
    for (int k = 0; k < LAT; k++) begin hv[k] = 1'b0; htag[k] = ""; end
    push($realtobits(5.0), $realtobits(-7.0), "R1 lane split");
    push($realtobits(3.75), $realtobits(-3.75), "R3 truncation");
    idle(3);
    push($realtobits(3.0e9), $realtobits(-1.0e10), "R4 out of range");
    push($realtobits(0.5), $realtobits(-0.999), "R5 fraction only");
    push($realtobits(1.0e9), $realtobits(-123456.0), "R5 exact integers");
    push(64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0001, "R6 NaNs");
    push(64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, "R6 infinities");
    idle(LAT + 2);
    push($realtobits(-2147483648.5), $realtobits(2147483647.75), "R7 range edges");
    push($realtobits(-2147483649.0), $realtobits(2147483648.0), "R7 just outside");
    push($realtobits(-2147483648.0), $realtobits(-2147483647.9), "R7 exact minimum");
    push(64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, "R8 signed zeros");
    push(64'h0000_0000_0000_0001, 64'h800F_FFFF_FFFF_FFFF, "R8 subnormals");
    idle(1);
    for (int i = 0; i < 72; i++) begin
      real a, b;
      a = (2.0 ** (i / 2 - 3)) * (1.0 + 0.37 * (i % 5));
      b = -a * 0.731;
      push($realtobits(a), $realtobits(b), "R3 sweep");
      if (i % 9 == 4) idle(i % 4);
    end
    for (int i = 0; i < 40; i++)
      push($realtobits(i * 1234567.25 - 2.5e7), $realtobits(-i * 987.5 + 3.0), "R9 burst");
    repeat (4) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b1;
    wait (stim_q.size() == 0);
    repeat (LAT + 4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule